// File: doc/BRIEF.md
# Region Page Table Walker

This block services a translation miss for a 32-bit virtual address using a flat, single-level page table that is split by region. The top two address bits pick one of three live regions: two per-process program regions and one shared system region. The fourth encoding is reserved. Each region owns a table base (a physical byte address) and a table length. The walker checks the 21-bit page number against the length of the selected region. If the check passes, it forms the entry address as base plus four times the page number, reads that 32-bit entry from memory over a request/valid handshake, and hands the entry back with a one-cycle completion pulse so that it can be inserted into the translation cache. If the check fails, it raises a one-cycle fault with a cause code and makes no memory access.

In the second program region, valid pages are packed against the top of the region. Its check is therefore inverted: a page number below the length is out of range. The 9-bit byte offset within a 512-byte page plays no part in the walk. Software loads the base and length registers through a small write port. A context switch rewrites only the four program-region registers. The system pair is left alone.

Top module: `rgn_ptw`

## Requirements
- R1: Address bits [31:30] pick the region: 0 is the first program region, 1 the second program region, 2 system space. Code 3 ends the walk with `fault_kind` = 2 and no memory request. Bits [8:0] do not change the entry address.
- R2: The page number is bits [29:9]. In region 0 and region 2, a page number greater than or equal to that region's length ends the walk with `fault_kind` = 1 and no memory request.
- R3: In region 1, a page number strictly less than the length ends the walk with `fault_kind` = 1. A page number greater than or equal to the length is walked.
- R4: For a walked address, `mem_addr` equals the region base plus the page number shifted left by 2, modulo 2^32.
- R5: `mem_req` stays high with `mem_addr` unchanged until `mem_rvalid` is sampled. On the next cycle `done` is high for exactly one cycle, and `done_pte` holds the `mem_rdata` value of the response cycle.
- R6: `miss_ready` is high only when the walker is idle. A `miss_valid` seen while busy is ignored: the running walk keeps its address, and no second walk follows.
- R7: A write with `cfg_we` high uses `cfg_addr[2:1]` as the region (0 to 2) and `cfg_addr[0]` as the field (0 = base, all 32 bits of `cfg_wdata`; 1 = length, `cfg_wdata[21:0]`). A write with region code 3 changes nothing.
- R8: A register write made while a walk is running, or on the same clock edge that accepts the miss, affects only later walks.
- R9: After reset, all bases and lengths are 0, `miss_ready` is 1, and `mem_req`, `done` and `fault` are 0. As a result, any region-0 address faults, and region-1 page 0 is walked at address 0.
- R10: `fault` rises exactly two cycles after the accepting edge, lasts one cycle, and is never high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_va | input | 32 | Virtual address of the miss |
| miss_ready | output | 1 | Walker is idle and takes the miss |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Region in [2:1], field in [0] (0 base, 1 length) |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Entry read request, held until served |
| mem_addr | output | 32 | Physical byte address of the entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle pulse: entry is ready |
| done_pte | output | 32 | Entry fetched for the completed walk |
| fault | output | 1 | One-cycle pulse: walk ended in a fault |
| fault_kind | output | 2 | 1 = length violation, 2 = reserved region, 0 otherwise |

## Verification
A register write and the acceptance of a miss can land on the same clock edge. In the bench, `cfg_we` is held high across the accepting edge in one test and across the edge that leaves the check stage in another. In each case the write moves the base of the region being walked, or shrinks its length. The bench judges the result at the ports: the walk in flight must read from the address implied by the old values, and the next walk to the same address must read from the new base or raise a length fault.

// File: rtl/rgn_ptw_pkg.sv
package rgn_ptw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CHECK = 3'd1,
      ST_FETCH = 3'd2,
      ST_DONE  = 3'd3,
      ST_FAULT = 3'd4
   } walk_state_e;

   typedef enum logic [1:0] {
      FK_NONE   = 2'd0,
      FK_LENGTH = 2'd1,
      FK_REGION = 2'd2
   } fault_kind_e;

endpackage

// File: rtl/rgn_ptw_regs.sv
module rgn_ptw_regs #(
   parameter int NUM_RGN    = 3,
   parameter int CFG_A_W    = 3,
   parameter int CFG_DATA_W = 32,
   parameter int PA_W       = 32,
   parameter int LEN_W      = 22
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [CFG_A_W-1:0]                cfg_addr,
   input  logic [CFG_DATA_W-1:0]             cfg_wdata,
   output logic [NUM_RGN-1:0][PA_W-1:0]      base_o,
   output logic [NUM_RGN-1:0][LEN_W-1:0]     len_o
);

   localparam int SEL_W = CFG_A_W - 1;

   logic [SEL_W-1:0] wr_rgn;
   logic             wr_len;

   assign wr_rgn = cfg_addr[CFG_A_W-1:1];
   assign wr_len = cfg_addr[0];

   for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_o[r] <= '0;
            len_o[r]  <= '0;
         end else if (cfg_we && (wr_rgn == SEL_W'(r))) begin
            if (wr_len) len_o[r]  <= cfg_wdata[LEN_W-1:0];
            else        base_o[r] <= cfg_wdata[PA_W-1:0];
         end
      end
   end

   // R7: writes to an unused region code leave every register untouched
   assert_rsvd_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (int'(wr_rgn) >= NUM_RGN)) |=> ($stable(base_o) && $stable(len_o)));

   // R7: a length write to region 0 lands in the region-0 length register
   assert_len_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && wr_len && (wr_rgn == '0)) |=> (len_o[0] == $past(cfg_wdata[LEN_W-1:0])));

endmodule

// File: rtl/rgn_ptw_check.sv
module rgn_ptw_check
   import rgn_ptw_pkg::*;
#(
   parameter int                 NUM_RGN   = 3,
   parameter int                 RGN_SEL_W = 2,
   parameter int                 VPN_W     = 21,
   parameter int                 LEN_W     = 22,
   parameter int                 PA_W      = 32,
   parameter int                 PTE_SHIFT = 2,
   parameter logic [NUM_RGN-1:0] DOWN_MASK = 3'b010
) (
   input  logic [RGN_SEL_W-1:0]          rgn_i,
   input  logic [VPN_W-1:0]              vpn_i,
   input  logic [NUM_RGN-1:0][PA_W-1:0]  base_i,
   input  logic [NUM_RGN-1:0][LEN_W-1:0] len_i,
   output fault_kind_e                   kind_o,
   output logic [PA_W-1:0]               addr_o
);

   logic [NUM_RGN-1:0]            viol;
   logic [LEN_W-1:0]              vpn_ext;
   logic [PA_W-1:0]               scaled;
   logic [NUM_RGN-1:0][PA_W-1:0]  sum;

   assign vpn_ext = LEN_W'(vpn_i);
   assign scaled  = PA_W'(vpn_i) << PTE_SHIFT;

   for (genvar r = 0; r < NUM_RGN; r++) begin : g_lim
      if (DOWN_MASK[r]) begin : g_down
         assign viol[r] = (vpn_ext < len_i[r]);
      end else begin : g_up
         assign viol[r] = (vpn_ext >= len_i[r]);
      end
      assign sum[r] = base_i[r] + scaled;
   end

   always_comb begin
      kind_o = FK_REGION;
      addr_o = '0;
      for (int r = 0; r < NUM_RGN; r++) begin
         if (rgn_i == RGN_SEL_W'(r)) begin
            kind_o = viol[r] ? FK_LENGTH : FK_NONE;
            addr_o = sum[r];
         end
      end
   end

endmodule

// File: rtl/rgn_ptw_walk.sv
module rgn_ptw_walk
   import rgn_ptw_pkg::*;
#(
   parameter int PA_W  = 32,
   parameter int PTE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   output logic              miss_ready,
   input  fault_kind_e       chk_kind,
   input  logic [PA_W-1:0]   chk_addr,
   output logic              mem_req,
   output logic [PA_W-1:0]   mem_addr,
   input  logic              mem_rvalid,
   input  logic [PTE_W-1:0]  mem_rdata,
   output logic              done,
   output logic [PTE_W-1:0]  done_pte,
   output logic              fault,
   output logic [1:0]        fault_kind
);

   walk_state_e       state;
   fault_kind_e       kind_q;
   logic [PA_W-1:0]   addr_q;
   logic [PTE_W-1:0]  pte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         kind_q <= FK_NONE;
         addr_q <= '0;
         pte_q  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (miss_valid) begin
               kind_q <= chk_kind;
               addr_q <= chk_addr;
               state  <= ST_CHECK;
            end
            ST_CHECK: state <= (kind_q != FK_NONE) ? ST_FAULT : ST_FETCH;
            ST_FETCH: if (mem_rvalid) begin
               pte_q <= mem_rdata;
               state <= ST_DONE;
            end
            ST_DONE:  state <= ST_IDLE;
            ST_FAULT: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign miss_ready = (state == ST_IDLE);
   assign mem_req    = (state == ST_FETCH);
   assign mem_addr   = addr_q;
   assign done       = (state == ST_DONE);
   assign done_pte   = pte_q;
   assign fault      = (state == ST_FAULT);
   assign fault_kind = (state == ST_FAULT) ? kind_q : FK_NONE;

   // R5: the request holds with a steady address until served
   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   // R5: a served request completes next cycle with the returned entry
   assert_done_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_rvalid) |=> (done && (done_pte == $past(mem_rdata))));

   // R5: completion is a single-cycle pulse
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: acceptance makes the walker busy on the next cycle
   assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready) |=> !miss_ready);

   // R10: fault and completion never coincide, and fault is a pulse
   assert_done_fault_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));
   assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);

endmodule

// File: rtl/rgn_ptw.sv
module rgn_ptw
   import rgn_ptw_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PA_W       = 32,
   parameter int PTE_W      = 32,
   parameter int PAGE_OFS_W = 9,
   parameter int RGN_SEL_W  = 2,
   parameter int NUM_RGN    = 3,
   parameter int PTE_BYTES  = 4,
   parameter int CFG_DATA_W = 32,
   parameter logic [NUM_RGN-1:0] DOWN_MASK = 3'b010,
   localparam int VPN_W     = VA_W - RGN_SEL_W - PAGE_OFS_W,
   localparam int LEN_W     = VPN_W + 1,
   localparam int CFG_A_W   = RGN_SEL_W + 1,
   localparam int PTE_SHIFT = $clog2(PTE_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  miss_valid,
   input  logic [VA_W-1:0]       miss_va,
   output logic                  miss_ready,
   input  logic                  cfg_we,
   input  logic [CFG_A_W-1:0]    cfg_addr,
   input  logic [CFG_DATA_W-1:0] cfg_wdata,
   output logic                  mem_req,
   output logic [PA_W-1:0]       mem_addr,
   input  logic                  mem_rvalid,
   input  logic [PTE_W-1:0]      mem_rdata,
   output logic                  done,
   output logic [PTE_W-1:0]      done_pte,
   output logic                  fault,
   output logic [1:0]            fault_kind
);

   if (VPN_W < 1) begin : g_bad_vpn
      $error("rgn_ptw: no page-number bits left");
   end
   if (NUM_RGN > (1 << RGN_SEL_W)) begin : g_bad_rgn
      $error("rgn_ptw: more regions than selector codes");
   end
   if ((1 << PTE_SHIFT) != PTE_BYTES) begin : g_bad_pte
      $error("rgn_ptw: entry size must be a power of two");
   end
   if ((CFG_DATA_W < PA_W) || (CFG_DATA_W < LEN_W)) begin : g_bad_cfg
      $error("rgn_ptw: write data narrower than a register");
   end

   logic [NUM_RGN-1:0][PA_W-1:0]  base_q;
   logic [NUM_RGN-1:0][LEN_W-1:0] len_q;
   logic [RGN_SEL_W-1:0]          rgn;
   logic [VPN_W-1:0]              vpn;
   fault_kind_e                   chk_kind;
   logic [PA_W-1:0]               chk_addr;

   assign rgn = miss_va[VA_W-1 -: RGN_SEL_W];
   assign vpn = miss_va[PAGE_OFS_W +: VPN_W];

   rgn_ptw_regs #(
      .NUM_RGN(NUM_RGN), .CFG_A_W(CFG_A_W), .CFG_DATA_W(CFG_DATA_W),
      .PA_W(PA_W), .LEN_W(LEN_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .base_o(base_q), .len_o(len_q)
   );

   rgn_ptw_check #(
      .NUM_RGN(NUM_RGN), .RGN_SEL_W(RGN_SEL_W), .VPN_W(VPN_W), .LEN_W(LEN_W),
      .PA_W(PA_W), .PTE_SHIFT(PTE_SHIFT), .DOWN_MASK(DOWN_MASK)
   ) u_check (
      .rgn_i(rgn), .vpn_i(vpn), .base_i(base_q), .len_i(len_q),
      .kind_o(chk_kind), .addr_o(chk_addr)
   );

   rgn_ptw_walk #(.PA_W(PA_W), .PTE_W(PTE_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
      .chk_kind(chk_kind), .chk_addr(chk_addr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .done(done), .done_pte(done_pte),
      .fault(fault), .fault_kind(fault_kind)
   );

   // R1: an unused region code faults two cycles after acceptance
   assert_rsvd_region_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready && (int'(rgn) >= NUM_RGN))
      |-> ##2 (fault && (fault_kind == FK_REGION) && !mem_req));

   // R4, R8: a passing check reads the address formed at acceptance
   assert_fetch_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready && (chk_kind == FK_NONE))
      |-> ##2 (mem_req && (mem_addr == $past(chk_addr, 2))));

endmodule

// File: tb/rgn_ptw_tb.sv
module rgn_ptw_tb;

   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC = 12;
   localparam logic [31:0] VECS [NVEC] = '{
      32'h0000_0000, 32'h0000_1E3F, 32'h0000_1E00, 32'h0000_2000,
      32'h7FFF_FFFF, 32'h7FFF_E000, 32'h7FFF_DE00, 32'h4000_0000,
      32'h8000_0200, 32'h8004_0000, 32'hC000_0000, 32'hFFFF_FFFF
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic [31:0] miss_va = '0;
   logic        miss_ready;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done;
   logic [31:0] done_pte;
   logic        fault;
   logic [1:0]  fault_kind;

   int checks = 0;
   int fails = 0;
   int mem_lat = 1;
   int mem_cnt = 0;
   logic [31:0] mem_last = '0;

   logic [31:0] m_base [3];
   logic [21:0] m_len  [3];

   bit          r_done, r_fault, r_pulse_ok, r_busy_low;
   logic [1:0]  r_kind;
   logic [31:0] r_pte, r_addr;
   int          r_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   rgn_ptw u_dut (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_va(miss_va),
      .miss_ready(miss_ready), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
      .done_pte(done_pte), .fault(fault), .fault_kind(fault_kind)
   );

   function automatic logic [31:0] pte_of(input logic [31:0] a);
      return a ^ 32'h5A00_00C3;
   endfunction

   // memory: answers a held request after mem_lat idle cycles
   always @(negedge clk) begin
      if (mem_req && !mem_rvalid) begin
         if (mem_cnt >= mem_lat) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= pte_of(mem_addr);
            mem_last   <= mem_addr;
            mem_cnt    <= 0;
         end else begin
            mem_cnt <= mem_cnt + 1;
         end
      end else begin
         mem_rvalid <= 1'b0;
         if (!mem_req) mem_cnt <= 0;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_kind(input logic [31:0] va);
      logic [1:0]  r;
      logic [21:0] v;
      r = va[31:30];
      v = {1'b0, va[29:9]};
      if (r == 2'd3) return 2'd2;
      if (r == 2'd1) return (v < m_len[1]) ? 2'd1 : 2'd0;
      return (v >= m_len[r]) ? 2'd1 : 2'd0;
   endfunction

   function automatic logic [31:0] exp_addr(input logic [31:0] va);
      return m_base[va[31:30]] + {9'd0, va[29:9], 2'b00};
   endfunction

   task automatic model_wr(input logic [2:0] a, input logic [31:0] d);
      if (a[2:1] != 2'd3) begin
         if (a[0]) m_len[a[2:1]] = d[21:0];
         else      m_base[a[2:1]] = d;
      end
   endtask

   task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      model_wr(a, d);
   endtask

   // one walk; optional write on the accepting edge or the edge after it,
   // optional busy-time request with another address
   task automatic do_walk(input logic [31:0] va, input bit wr_acc, input bit wr_mid,
                          input logic [2:0] wa, input logic [31:0] wd,
                          input bit hold, input logic [31:0] busy_va);
      @(negedge clk);
      miss_valid = 1'b1; miss_va = va;
      if (wr_acc) begin cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd; end
      @(negedge clk);
      r_n = 1;
      miss_valid = hold; miss_va = busy_va;
      cfg_we = wr_mid; cfg_addr = wa; cfg_wdata = wd;
      r_busy_low = !miss_ready;
      while (!(done || fault) && r_n < 200) begin
         @(negedge clk);
         cfg_we = 1'b0;
         r_n++;
      end
      r_done = done; r_fault = fault; r_kind = fault_kind;
      r_pte = done_pte; r_addr = mem_last;
      miss_valid = 1'b0;
      @(negedge clk);
      r_pulse_ok = !done && !fault && miss_ready && !mem_req;
   endtask

   task automatic judge(input logic [31:0] va, input string tag);
      logic [1:0]  ek;
      logic [31:0] ea;
      ek = exp_kind(va);
      ea = exp_addr(va);
      if (ek != 2'd0) begin
         chk(r_fault && !r_done && r_kind == ek, tag, {r_fault, r_kind}, {1'b1, ek});
         chk(r_n == 2, "R10 fault latency", r_n, 2);
      end else begin
         chk(r_done && !r_fault, tag, {r_done, r_fault}, 2'b10);
         chk(r_addr == ea, "R4 entry address", r_addr, ea);
         chk(r_pte == pte_of(ea), "R5 returned entry", r_pte, pte_of(ea));
      end
      chk(r_pulse_ok, "R5 single-cycle end pulse", r_pulse_ok, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 3; i++) begin m_base[i] = '0; m_len[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state at the ports
      chk(miss_ready && !mem_req && !done && !fault, "R9 reset outputs",
          {miss_ready, mem_req, done, fault}, 4'b1000);
      do_walk(32'h0000_0000, 0, 0, 3'd0, 0, 0, 0);
      judge(32'h0000_0000, "R9 zero length region 0 faults");
      do_walk(32'h4000_0000, 0, 0, 3'd0, 0, 0, 0);
      judge(32'h4000_0000, "R9 zero length region 1 walks");

      // R7: program all three regions
      cfg_write(3'b000, 32'h0010_0000); cfg_write(3'b001, 32'd16);
      cfg_write(3'b010, 32'h0020_0000); cfg_write(3'b011, 32'h001F_FFF0);
      cfg_write(3'b100, 32'h0030_0000); cfg_write(3'b101, 32'h0000_0200);

      // table walk: R1 R2 R3 R4 across regions and boundaries
      for (int i = 0; i < NVEC; i++) begin
         mem_lat = i % 4;
         do_walk(VECS[i], 0, 0, 3'd0, 0, 0, 0);
         judge(VECS[i], "R1/R2/R3 vector outcome");
      end

      // R7: writes to region code 3 are ignored
      cfg_write(3'b110, 32'hDEAD_BEEF);
      cfg_write(3'b111, 32'h0000_0000);
      do_walk(32'h0000_1A00, 0, 0, 3'd0, 0, 0, 0);
      judge(32'h0000_1A00, "R7 reserved write ignored, region 0");
      do_walk(32'h8000_0400, 0, 0, 3'd0, 0, 0, 0);
      judge(32'h8000_0400, "R7 reserved write ignored, system");

      // R8: write on the accepting edge affects only the next walk
      do_walk(32'h0000_0A00, 1, 0, 3'b000, 32'h0050_0000, 0, 0);
      judge(32'h0000_0A00, "R8 same-edge base write deferred");
      model_wr(3'b000, 32'h0050_0000);
      do_walk(32'h0000_0A00, 0, 0, 3'd0, 0, 0, 0);
      judge(32'h0000_0A00, "R8 new base used next walk");

      // R8: length shrink during the walk affects only the next walk
      mem_lat = 3;
      do_walk(32'h0000_0A00, 0, 1, 3'b001, 32'd2, 0, 0);
      judge(32'h0000_0A00, "R8 mid-walk length write deferred");
      model_wr(3'b001, 32'd2);
      do_walk(32'h0000_0A00, 0, 0, 3'd0, 0, 0, 0);
      judge(32'h0000_0A00, "R8 shrunk length faults next walk");

      // R6: request held while busy is ignored
      mem_lat = 4;
      do_walk(32'h8000_0600, 0, 0, 3'd0, 0, 1, 32'h4000_0000);
      judge(32'h8000_0600, "R6 busy request ignored");
      chk(r_busy_low, "R6 ready low while busy", r_busy_low, 1);
      @(negedge clk);
      chk(miss_ready && !mem_req, "R6 no second walk", {miss_ready, mem_req}, 2'b10);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule